// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that software drives through a small byte-addressed register file. Software first programs the frame format, the clock divider and the control bits. Each write to the data register then queues one frame. The block generates the serial clock, shifts the frame out on `mosi`, samples `miso` and holds the active-low select `ss_n` low around the transfer.

A one-entry transmit buffer sits in front of the shift register, so software can queue one more frame while the current one is shifting. In full-duplex mode every finished frame lands in a receive buffer that a data-register read empties. Software that only wants to receive writes a dummy word to generate the clocks. In transmit-only mode the receive side is left untouched.

The interrupt output combines the status flags with their enable bits. Clearing either the master bit or the enable bit stops the shift engine at once.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the control register (offset 0x00) and the command register (offset 0x10) read 0, and status (offset 0x03) reads 0x20. The outputs are `sck`=0, `ss_n`=1 and `irq`=0.
- R2: With the rate register (offset 0x0A) holding B, every serial clock half period lasts B+1 clock cycles. `ss_n` falls one half period before the first clock edge and rises one half period after the last one.
- R3: Command bits 11:8 hold the frame length minus one, so values 7 to 15 give 8 to 16 bits. Values below 7 give 8 bits, and data-word bits above the frame length are not sent.
- R4: Command bit 12 set sends and receives the least significant bit first. Clear, the most significant bit goes first.
- R5: Command bit 1 is the idle level of `sck`. With command bit 0 clear, data is sampled on the leading edge of each clock pulse; with it set, data is sampled on the trailing edge.
- R6: In full-duplex mode (control bit 1 clear) a finished frame sets status bit 7. A read of the data register (offset 0x04) returns the received frame right-aligned and clears bit 7.
- R7: In transmit-only mode (control bit 1 set) a finished frame leaves status bit 7 and the receive data unchanged.
- R8: A full-duplex frame that ends while status bit 7 is set sets status bit 0 (overrun) and is discarded. Writing 0 to status bit 0 clears it, and writing 1 leaves it set.
- R9: Status bit 5 clears on a data write and sets when the word moves into the shift register. A word queued during a frame follows it without `ss_n` rising in between.
- R10: `irq` is high exactly when status bit 7 with control bit 7, status bit 5 with control bit 5, or status bit 0 with control bit 4 are both set.
- R11: The engine runs only while control bit 3 (master) and control bit 6 (enable) are both set. Clearing either one mid-frame drives `ss_n` high and `sck` to its idle level.
- R12: With command bit 7 set, `ss_n` stays low after a frame. It rises once bit 7 is cleared while the engine is idle.
- R13: A data write while status bit 5 is clear is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on the data register) |
| addr | input | AW | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |

## Verification
Two situations are hard to reach from the ports.

The first is overrun. It needs a second full-duplex frame to finish while the first is still unread. The stimulus deliberately skips the data read between two dummy writes, then probes the clear-by-zero rule.

The second is the queued-frame handoff. The second data write must land after the first word has left the buffer but before that frame ends. The bench slows the clock divider and places the write a few cycles after the first. A third write then checks the dropped-write rule. A slave model counts `ss_n` rises to confirm the select stayed low across the handoff.

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          irq,
  output logic          sck,
  output logic          mosi,
  output logic          ss_n,
  input  logic          miso
);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h03);
  localparam logic [AW-1:0] A_DATA = AW'(8'h04);
  localparam logic [AW-1:0] A_RATE = AW'(8'h0A);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h10);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TRAIL} st_t;

  logic [7:0]  ctrl, rate, cnt;
  logic [15:0] cmd, txbuf, rxbuf, tsh, rsh, rx_next;
  logic        txe, rxf, ovr;
  st_t         st;
  logic [5:0]  edge_n;
  logic [4:0]  flen;
  logic        f_lsb, f_cpha, f_txo, sck_r, ss_r;

  wire       active   = ctrl[3] & ctrl[6];
  wire       tick     = (cnt == rate);
  wire       wr_data  = wr_en && addr == A_DATA;
  wire       rd_data  = rd_en && addr == A_DATA;
  wire [4:0] cmd_len  = (cmd[11:8] < 4'd7) ? 5'd8 : {1'b0, cmd[11:8]} + 5'd1;
  wire       last_e   = st == S_SHIFT && tick && edge_n == ({flen, 1'b0} - 6'd1);
  wire       sample   = edge_n[0] == f_cpha;
  wire       shift_o  = !sample && edge_n != 6'd0;
  wire       load     = active && !txe && (st == S_IDLE || (st == S_TRAIL && tick));
  wire [3:0] msb_i    = 4'(flen - 5'd1);

  assign mosi = f_lsb ? tsh[0] : tsh[msb_i];
  assign sck  = sck_r;
  assign ss_n = ss_r;
  assign irq  = (rxf & ctrl[7]) | (txe & ctrl[5]) | (ovr & ctrl[4]);

  always_comb begin
    rx_next = rsh;
    if (sample) begin
      if (f_lsb) rx_next[edge_n[4:1]] = miso;
      else       rx_next = {rsh[14:0], miso};
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {8'h00, ctrl};
      A_STAT:  rdata = {8'h00, rxf, 1'b0, txe, 4'b0000, ovr};
      A_DATA:  rdata = rxbuf;
      A_RATE:  rdata = {8'h00, rate};
      A_CMD:   rdata = cmd;
      default: rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rate <= '0; cmd <= '0; txbuf <= '0; rxbuf <= '0;
      txe <= 1'b1; rxf <= 1'b0; ovr <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTRL: ctrl <= wdata[7:0];
          A_RATE: rate <= wdata[7:0];
          A_CMD:  cmd  <= wdata;
          A_STAT: if (!wdata[0]) ovr <= 1'b0;
          A_DATA: if (txe) begin txbuf <= wdata; txe <= 1'b0; end
          default: ;
        endcase
      end
      if (load) txe <= 1'b1;
      if (rd_data) rxf <= 1'b0;
      if (last_e && !f_txo) begin
        if (rxf && !rd_data) ovr <= 1'b1;
        else begin rxbuf <= rx_next; rxf <= 1'b1; end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; edge_n <= '0; sck_r <= 1'b0; ss_r <= 1'b1;
      tsh <= '0; rsh <= '0; flen <= 5'd8; f_lsb <= 1'b0; f_cpha <= 1'b0; f_txo <= 1'b0;
    end else if (!active) begin
      st <= S_IDLE; cnt <= '0; edge_n <= '0; sck_r <= cmd[1]; ss_r <= 1'b1;
    end else begin
      if (load) begin
        tsh <= txbuf; rsh <= '0; flen <= cmd_len; f_lsb <= cmd[12];
        f_cpha <= cmd[0]; f_txo <= ctrl[1]; cnt <= '0; edge_n <= '0;
        ss_r <= 1'b0; st <= S_SHIFT;
      end else begin
        case (st)
          S_IDLE: begin
            sck_r <= cmd[1];
            if (!cmd[7]) ss_r <= 1'b1;
          end
          S_SHIFT: begin
            if (tick) begin
              cnt <= '0;
              sck_r <= ~sck_r;
              rsh <= rx_next;
              edge_n <= last_e ? 6'd0 : edge_n + 6'd1;
              if (shift_o) tsh <= f_lsb ? (tsh >> 1) : (tsh << 1);
              if (last_e) st <= S_TRAIL;
            end else cnt <= cnt + 8'd1;
          end
          S_TRAIL: begin
            if (tick) begin
              cnt <= '0;
              st <= S_IDLE;
              if (!cmd[7]) ss_r <= 1'b1;
            end else cnt <= cnt + 8'd1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_off_releases_ss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ss_n);
  assert_txonly_keeps_rxf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxf) |-> !f_txo);
  assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rxf));
  assert_rxf_cleared_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxf) |-> $past(rd_en && addr == A_DATA));
  assert_txe_cleared_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txe) |-> $past(wr_en && addr == A_DATA));
endmodule

// File: tb/spi_master_regs_test.sv
module spi_master_regs_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, miso = 0;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq, sck, mosi, ss_n;

  spi_master_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int t_len = 8, t_baud = 0;
  logic t_lsb = 0, t_cpol = 0, t_cpha = 0;
  logic [15:0] t_miso = 0;
  int frames = 0, ss_rises = 0, partial = 0, gap_err = 0, ec = 0, mi = 0, si = 0, last_evt = 0;
  logic prev_sck = 0, prev_ss = 1, cont = 0, lead = 0;
  logic [15:0] cap = 0;
  logic [15:0] caps [0:7];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sbit(int i);
    if (i >= t_len) return 1'b0;
    return t_lsb ? t_miso[i] : t_miso[t_len-1-i];
  endfunction

  function automatic logic [15:0] msk(int l);
    return 16'((32'h1 << l) - 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ss && !ss_n) begin
        ec = 0; mi = 0; si = 0; cap = 0; cont = 0; last_evt = cyc;
        if (!t_cpha) miso = sbit(0);
      end else if (!prev_ss && ss_n) begin
        ss_rises++;
        if (ec != 0) partial++;
        if (cyc - last_evt != t_baud + 1) gap_err++;
      end else if (!ss_n && sck != prev_sck) begin
        lead = (prev_sck == t_cpol);
        if (cyc - last_evt != ((cont && ec == 0) ? 2 : 1) * (t_baud + 1)) gap_err++;
        ec++;
        if (lead != t_cpha) begin
          if (t_lsb) cap[si] = mosi; else cap = {cap[14:0], mosi};
          si++;
        end else if (t_cpha) begin
          miso = sbit(mi); mi++;
        end else if (ec < 2 * t_len) begin
          mi++; miso = sbit(mi);
        end
        if (ec == 2 * t_len) begin
          caps[frames % 8] = cap; frames++;
          ec = 0; mi = 0; si = 0; cap = 0; cont = 1;
          if (!t_cpha) miso = sbit(0);
        end
        last_evt = cyc;
      end
      prev_sck = sck; prev_ss = ss_n;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cfg(input logic [7:0] ctl, input int b, input int len, input logic lsb,
                     input logic keep, input logic cpol, input logic cpha, input logic [3:0] lfield);
    t_baud = b; t_len = len; t_lsb = lsb; t_cpol = cpol; t_cpha = cpha;
    wr(8'h10, {3'b000, lsb, lfield, keep, 5'b00000, cpol, cpha});
    wr(8'h0A, 16'(b));
    wr(8'h00, {8'h00, ctl});
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
    repeat (t_baud + 4) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] d, input logic [15:0] mw, input logic txonly, input string tag);
    logic [15:0] v;
    int base;
    base = frames; t_miso = mw;
    wr(8'h04, d);
    wait_frames(base + 1);
    chk(caps[(frames - 1) % 8] == (d & msk(t_len)), tag, caps[(frames - 1) % 8], d & msk(t_len));
    if (!txonly) begin
      rd(8'h03, v); chk(v[7] == 1'b1, "R6 rxf set", v, 16'h00a0);
      rd(8'h04, v); chk(v == (mw & msk(t_len)), tag, v, mw & msk(t_len));
      rd(8'h03, v); chk(v[7] == 1'b0, "R6 rxf cleared", v, 16'h0020);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base, r0, unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, v); chk(v == 16'h0000, "R1 ctrl reset", v, 16'h0000);
    rd(8'h10, v); chk(v == 16'h0000, "R1 cmd reset", v, 16'h0000);
    rd(8'h03, v); chk(v == 16'h0020, "R1 status reset", v, 16'h0020);
    chk(sck == 0 && ss_n == 1 && irq == 0, "R1 pins reset", {13'b0, sck, ss_n, irq}, 16'h0002);

    cfg(8'h48, 0, 8, 0, 0, 0, 0, 4'h7);
    frame(16'h00a5, 16'h003c, 0, "R4 msb-first mode0 data");
    cfg(8'h48, 2, 16, 1, 0, 1, 1, 4'hf);
    frame(16'h1234, 16'hbeef, 0, "R4 R5 lsb-first mode3 data");
    chk(sck == 1'b1, "R5 idle level cpol1", {15'b0, sck}, 16'h0001);
    cfg(8'h48, 1, 8, 0, 0, 0, 1, 4'h3);
    frame(16'h01ff, 16'h0081, 0, "R3 short length code");
    cfg(8'h48, 1, 12, 0, 0, 1, 0, 4'hb);
    frame(16'hfabc, 16'h0765, 0, "R3 12-bit frame");

    cfg(8'h4a, 1, 8, 0, 0, 0, 0, 4'h7);
    frame(16'h0055, 16'h00ff, 1, "R7 txonly data");
    rd(8'h03, v); chk(v == 16'h0020, "R7 no rxf in txonly", v, 16'h0020);

    cfg(8'h48, 0, 8, 0, 0, 0, 0, 4'h7);
    base = frames; t_miso = 16'h0011; wr(8'h04, 16'h0001); wait_frames(base + 1);
    t_miso = 16'h0022; wr(8'h04, 16'h0002); wait_frames(base + 2);
    rd(8'h03, v); chk(v == 16'h00a1, "R8 overrun set", v, 16'h00a1);
    wr(8'h00, 16'h0058);
    @(negedge clk); chk(irq == 1'b1, "R10 irq from overrun", {15'b0, irq}, 16'h0001);
    wr(8'h03, 16'h0001);
    rd(8'h03, v); chk(v[0] == 1'b1, "R8 write one keeps overrun", v, 16'h00a1);
    wr(8'h03, 16'h0000);
    rd(8'h03, v); chk(v[0] == 1'b0, "R8 write zero clears", v, 16'h00a0);
    rd(8'h04, v); chk(v == 16'h0011, "R8 second frame discarded", v, 16'h0011);
    wr(8'h00, 16'h00c8);
    t_miso = 16'h0033; base = frames; wr(8'h04, 16'h0003); wait_frames(base + 1);
    chk(irq == 1'b1, "R10 irq from rxf", {15'b0, irq}, 16'h0001);
    rd(8'h04, v);
    @(negedge clk); chk(irq == 1'b0, "R10 irq drops after read", {15'b0, irq}, 16'h0000);
    wr(8'h00, 16'h0068);
    @(negedge clk); chk(irq == 1'b1, "R10 irq from txe", {15'b0, irq}, 16'h0001);

    cfg(8'h4a, 3, 8, 0, 0, 0, 0, 4'h7);
    base = frames; r0 = ss_rises;
    wr(8'h04, 16'h00c3);
    repeat (2) @(negedge clk);
    wr(8'h04, 16'h003d);
    rd(8'h03, v); chk(v[5] == 1'b0, "R9 txe clear while queued", v, 16'h0000);
    wr(8'h04, 16'h00ee);
    wait_frames(base + 2);
    repeat (60) @(negedge clk);
    chk(frames == base + 2, "R13 third write dropped", 16'(frames - base), 16'd2);
    chk(caps[base % 8] == 16'h00c3, "R9 first queued frame", caps[base % 8], 16'h00c3);
    chk(caps[(base + 1) % 8] == 16'h003d, "R9 second queued frame", caps[(base + 1) % 8], 16'h003d);
    chk(ss_rises == r0 + 1, "R9 select held across frames", 16'(ss_rises - r0), 16'd1);

    for (int i = 0; i < 30; i++) begin
      int len;
      len = 8 + int'($urandom % 9);
      cfg(8'h48, int'($urandom % 4), len, 1'($urandom), 0, 1'($urandom), 1'($urandom), 4'(len - 1));
      frame(16'($urandom), 16'($urandom), 0, "R3 R4 R5 R6 random frame");
    end

    chk(gap_err == 0, "R2 half-period timing", 16'(gap_err), 16'd0);
    chk(partial == 0, "R3 whole frames only", 16'(partial), 16'd0);

    cfg(8'h4a, 1, 8, 0, 1, 0, 0, 4'h7);
    base = frames; wr(8'h04, 16'h0077); wait_frames(base + 1);
    repeat (20) @(negedge clk);
    chk(ss_n == 1'b0, "R12 select kept low", {15'b0, ss_n}, 16'h0000);
    wr(8'h10, 16'h0700);
    repeat (2) @(negedge clk);
    chk(ss_n == 1'b1, "R12 select released", {15'b0, ss_n}, 16'h0001);

    cfg(8'h48, 7, 16, 0, 0, 1, 0, 4'hf);
    wr(8'h04, 16'h5a5a);
    repeat (40) @(negedge clk);
    chk(ss_n == 1'b0, "R11 busy before disable", {15'b0, ss_n}, 16'h0000);
    wr(8'h00, 16'h0008);
    repeat (2) @(negedge clk);
    chk(ss_n == 1'b1 && sck == 1'b1, "R11 disable idles pins", {14'b0, ss_n, sck}, 16'h0003);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule